// File: doc/BRIEF.md
# Miss-Driven Cache Resize Controller

This block decides how much of a cache stays powered. The cache is split into a power-of-two number of equal sections. The active size is always a power of two sections, and it is tracked as a size index `k`, meaning that `2^k` sections are on. The controller watches a retire strobe and a miss strobe. It closes an evaluation interval after a programmed number of retired instructions. It then compares the misses counted in that interval with a programmed threshold and moves the size one step: it doubles the active size, halves it, or holds it. The index never falls below a configured minimum, which keeps the cache from collapsing and thrashing. It never rises above the full size.

The controller has two states. In `ST_COUNT` the block is only counting. The transition `COUNT_TO_EVAL` is taken in the cycle that retires the last instruction of an interval. In that cycle the final miss count and the threshold are captured. In `ST_EVAL` the captured values are compared and the index is updated. Then `EVAL_TO_COUNT` returns to counting. If another interval closes during `ST_EVAL`, the transition `EVAL_TO_EVAL` stays in `ST_EVAL`, so no interval is lost.

The section-enable mask is a thermometer code taken from the index, and it drives the power gates directly. A one-cycle pulse marks every change of the index. Any remapping or flushing of lines held in sections that are switched off is left to the surrounding cache.

Top module: `cache_resize_ctrl`

## Requirements
- R1: While reset is held and right after it is released, the size index equals log2(N_SECT) (full size), every mask bit is 1 and the resize pulse is 0.
- R2: An interval closes on the retire that brings the retired count to the interval length. The index update for that interval is visible after the second rising edge counted from the edge that samples that retire.
- R3: If the interval's miss count is greater than the threshold, the index rises by one, which doubles the active sections. An index already at log2(N_SECT) stays there.
- R4: If the interval's miss count is less than the threshold, the index falls by one, which halves the active sections. The index never goes below MIN_IDX.
- R5: If the miss count equals the threshold, the index is unchanged and no pulse is raised.
- R6: The retire counter and the miss counter both restart at each interval close. A miss flagged in the closing cycle is counted in the new interval and not in the one that closes.
- R7: Mask bit j is 1 exactly when j < 2^index. Bit 0 is always 1.
- R8: The resize pulse is high for exactly one cycle, in the first cycle in which the new index is visible, and only when the index has changed.
- R9: An interval length of 0 acts as 1. The miss counter saturates at 2^CNT_W-1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | One instruction retired this cycle |
| miss_i | input | 1 | One cache miss this cycle |
| thresh_i | input | CNT_W | Miss threshold per interval |
| interval_i | input | INT_W | Interval length in retired instructions |
| size_idx_o | output | IDX_W | Current size index, log2 of active sections |
| sect_en_o | output | N_SECT | Per-section power enable, thermometer coded |
| resize_o | output | 1 | One-cycle pulse on each index change |

## Verification
The assertions assume that reset is held across at least one rising edge before it is released. The single-step and pulse properties compare against the previous cycle's index, and that edge gives them a defined value. They also assume that the retire and miss strobes are known values in every cycle after reset. The bench holds reset for several edges and drives both strobes only at falling edges with 0 or 1. It changes the threshold and the interval length only while no interval is being closed, so the values captured at a close are the values the reference model used.

// File: rtl/cr_pkg.sv
package cr_pkg;

    // Controller states
    typedef enum logic [0:0] {
        ST_COUNT = 1'b0,   // accumulating retires and misses
        ST_EVAL  = 1'b1    // applying the decision of the interval just closed
    } cr_state_e;

    // Resize direction decided from a closed interval
    typedef enum logic [1:0] {
        DIR_HOLD   = 2'd0,
        DIR_GROW   = 2'd1,
        DIR_SHRINK = 2'd2
    } cr_dir_e;

endpackage

// File: rtl/cr_interval_cnt.sv
// Counts retired instructions and flags the retire that closes an interval.
module cr_interval_cnt #(
    parameter int INT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic [INT_W-1:0] interval_i,
    output logic             close_o
);

    logic [INT_W-1:0] icnt_q;
    logic [INT_W:0]   eff_len;
    logic [INT_W:0]   icnt_inc;

    // A length of zero behaves as a length of one
    always_comb begin
        if (interval_i == '0) begin
            eff_len = (INT_W+1)'(1);
        end else begin
            eff_len = {1'b0, interval_i};
        end
        icnt_inc = {1'b0, icnt_q} + (INT_W+1)'(1);
    end

    // Greater-or-equal also closes at once if the length was lowered mid-interval
    assign close_o = retire_i && (icnt_inc >= eff_len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            icnt_q <= '0;
        end else if (close_o) begin
            icnt_q <= '0;
        end else if (retire_i) begin
            icnt_q <= icnt_inc[INT_W-1:0];
        end
    end

endmodule

// File: rtl/cr_miss_cnt.sv
// Saturating miss counter that restarts at an interval close.
module cr_miss_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_i,
    input  logic             close_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] mcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcnt_q <= '0;
        end else if (close_i) begin
            // a miss in the closing cycle opens the new interval's tally
            mcnt_q <= CNT_W'(miss_i);
        end else if (miss_i && (mcnt_q != CNT_MAX)) begin
            mcnt_q <= mcnt_q + CNT_W'(1);
        end
    end

    assign count_o = mcnt_q;

endmodule

// File: rtl/cr_resize_fsm.sv
// Captures a closed interval's tally and steps the size index.
module cr_resize_fsm
    import cr_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int IDX_W   = 3,
    parameter int MIN_IDX = 1,
    parameter int MAX_IDX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             close_i,
    input  logic [CNT_W-1:0] miss_cnt_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             resize_o
);

    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(MAX_IDX);
    localparam logic [IDX_W-1:0] IDX_BOT = IDX_W'(MIN_IDX);

    cr_state_e        state_q, state_nx;
    cr_dir_e          dir;
    logic [CNT_W-1:0] snap_cnt_q;
    logic [CNT_W-1:0] snap_thr_q;
    logic [IDX_W-1:0] idx_q, idx_nx;
    logic             resize_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COUNT;
        end else begin
            state_q <= state_nx;
        end
    end

    // Transitions: COUNT_TO_EVAL, EVAL_TO_EVAL, EVAL_TO_COUNT
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_COUNT: state_nx = close_i ? ST_EVAL : ST_COUNT;
            ST_EVAL:  state_nx = close_i ? ST_EVAL : ST_COUNT;
            default:  state_nx = ST_COUNT;
        endcase
    end

    // Direction from the captured tally
    always_comb begin
        if (snap_cnt_q > snap_thr_q) begin
            dir = DIR_GROW;
        end else if (snap_cnt_q < snap_thr_q) begin
            dir = DIR_SHRINK;
        end else begin
            dir = DIR_HOLD;
        end
    end

    // Saturating one-step move
    always_comb begin
        idx_nx = idx_q;
        unique case (dir)
            DIR_GROW:   idx_nx = (idx_q >= IDX_TOP) ? IDX_TOP : idx_q + IDX_W'(1);
            DIR_SHRINK: idx_nx = (idx_q <= IDX_BOT) ? IDX_BOT : idx_q - IDX_W'(1);
            DIR_HOLD:   idx_nx = idx_q;
            default:    idx_nx = idx_q;
        endcase
    end

    // Outputs and captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_cnt_q <= '0;
            snap_thr_q <= '0;
            idx_q      <= IDX_TOP;
            resize_q   <= 1'b0;
        end else begin
            if (close_i) begin
                snap_cnt_q <= miss_cnt_i;
                snap_thr_q <= thresh_i;
            end
            unique case (state_q)
                ST_EVAL: begin
                    idx_q    <= idx_nx;
                    resize_q <= (idx_nx != idx_q);
                end
                default: begin
                    resize_q <= 1'b0;
                end
            endcase
        end
    end

    assign idx_o    = idx_q;
    assign resize_o = resize_q;

endmodule

// File: rtl/cr_sect_mask.sv
// Thermometer enable mask: section j is on when j < 2^idx.
module cr_sect_mask #(
    parameter int N_SECT = 16,
    parameter int IDX_W  = 3
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [N_SECT-1:0] en_o
);

    logic [31:0] active_n;

    assign active_n = 32'(1) << idx_i;

    for (genvar j = 0; j < N_SECT; j++) begin : g_sect
        assign en_o[j] = (active_n > 32'(j));
    end

endmodule

// File: rtl/cache_resize_ctrl.sv
module cache_resize_ctrl #(
    parameter int N_SECT  = 16,
    parameter int MIN_IDX = 1,
    parameter int CNT_W   = 8,
    parameter int INT_W   = 12,
    localparam int MAX_IDX = $clog2(N_SECT),
    localparam int IDX_W   = $clog2(MAX_IDX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire_i,
    input  logic              miss_i,
    input  logic [CNT_W-1:0]  thresh_i,
    input  logic [INT_W-1:0]  interval_i,
    output logic [IDX_W-1:0]  size_idx_o,
    output logic [N_SECT-1:0] sect_en_o,
    output logic              resize_o
);

    logic             close;
    logic [CNT_W-1:0] miss_cnt;

    cr_interval_cnt #(.INT_W(INT_W)) u_icnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .retire_i   (retire_i),
        .interval_i (interval_i),
        .close_o    (close)
    );

    cr_miss_cnt #(.CNT_W(CNT_W)) u_mcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .miss_i  (miss_i),
        .close_i (close),
        .count_o (miss_cnt)
    );

    cr_resize_fsm #(
        .CNT_W   (CNT_W),
        .IDX_W   (IDX_W),
        .MIN_IDX (MIN_IDX),
        .MAX_IDX (MAX_IDX)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .close_i    (close),
        .miss_cnt_i (miss_cnt),
        .thresh_i   (thresh_i),
        .idx_o      (size_idx_o),
        .resize_o   (resize_o)
    );

    cr_sect_mask #(.N_SECT(N_SECT), .IDX_W(IDX_W)) u_mask (
        .idx_i (size_idx_o),
        .en_o  (sect_en_o)
    );

endmodule

// File: rtl/cache_resize_ctrl_chk.sv
module cache_resize_ctrl_chk #(
    parameter int N_SECT  = 16,
    parameter int MIN_IDX = 1,
    localparam int MAX_IDX = $clog2(N_SECT),
    localparam int IDX_W   = $clog2(MAX_IDX + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              retire_i,
    input logic [IDX_W-1:0]  size_idx_o,
    input logic [N_SECT-1:0] sect_en_o,
    input logic              resize_o
);

    AST_IDX_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(size_idx_o) >= MIN_IDX) && (int'(size_idx_o) <= MAX_IDX)); // R4

    AST_MASK_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sect_en_o) == (1 << size_idx_o)); // R7

    AST_MASK_BASE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        sect_en_o[0]); // R7

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (size_idx_o != $past(size_idx_o)) |->
        ((int'(size_idx_o) == int'($past(size_idx_o)) + 1) ||
         (int'(size_idx_o) == int'($past(size_idx_o)) - 1))); // R3

    AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        resize_o == (size_idx_o != $past(size_idx_o))); // R8

    AST_RESIZE_NEEDS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        resize_o |-> $past(retire_i, 2)); // R2

endmodule

bind cache_resize_ctrl cache_resize_ctrl_chk #(
    .N_SECT  (N_SECT),
    .MIN_IDX (MIN_IDX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .retire_i   (retire_i),
    .size_idx_o (size_idx_o),
    .sect_en_o  (sect_en_o),
    .resize_o   (resize_o)
);

// File: tb/cache_resize_ctrl_tb.sv
`timescale 1ns/1ps
module cache_resize_ctrl_tb;

    localparam int N_SECT  = 16;
    localparam int MIN_IDX = 1;
    localparam int CNT_W   = 8;
    localparam int INT_W   = 12;
    localparam int MAX_IDX = 4;
    localparam int IDX_W   = 3;
    localparam int CMAX    = 255;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              retire = 1'b0;
    logic              miss = 1'b0;
    logic [CNT_W-1:0]  thr = '0;
    logic [INT_W-1:0]  len = '0;
    logic [IDX_W-1:0]  size_idx;
    logic [N_SECT-1:0] sect_en;
    logic              resize;

    int total = 0;
    int bad = 0;

    // reference model state
    int  m_icnt, m_miss, m_idx, m_dir, m_eff, m_new;
    bit  m_pend, m_pulse;

    always #2.5 clk = ~clk;

    cache_resize_ctrl #(
        .N_SECT(N_SECT), .MIN_IDX(MIN_IDX), .CNT_W(CNT_W), .INT_W(INT_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .retire_i(retire), .miss_i(miss),
        .thresh_i(thr), .interval_i(len),
        .size_idx_o(size_idx), .sect_en_o(sect_en), .resize_o(resize)
    );

    function automatic int exp_mask(int idx);
        return (1 << (1 << idx)) - 1;
    endfunction

    task automatic chk(string tag, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
        end
    endtask

    // behavioural model and per-cycle comparison
    always @(posedge clk) begin
        if (!rst_n) begin
            m_icnt = 0; m_miss = 0; m_idx = MAX_IDX; m_pend = 0; m_pulse = 0; m_dir = 0;
        end else begin
            m_eff = (len == 0) ? 1 : int'(len);
            m_pulse = 0;
            if (m_pend) begin
                m_new = m_idx + m_dir;
                if (m_new > MAX_IDX) m_new = MAX_IDX;
                if (m_new < MIN_IDX) m_new = MIN_IDX;
                m_pulse = (m_new != m_idx);
                m_idx = m_new;
            end
            if (retire && (m_icnt + 1 >= m_eff)) begin
                m_pend = 1;
                m_dir = (m_miss > int'(thr)) ? 1 : ((m_miss < int'(thr)) ? -1 : 0);
                m_miss = miss ? 1 : 0;
                m_icnt = 0;
            end else begin
                m_pend = 0;
                if (retire) m_icnt++;
                if (miss && m_miss < CMAX) m_miss++;
            end
            #1;
            chk("R2 size index", int'(size_idx), m_idx);
            chk("R7 mask", int'(sect_en), exp_mask(m_idx));
            chk("R8 pulse", int'(resize), int'(m_pulse));
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            retire = 1'b0;
            miss = 1'b0;
        end
    endtask

    // one interval of len retires; misses on the first n_miss, bmiss on the closing one
    task automatic run_interval(int n_miss, bit bmiss);
        for (int i = 0; i < int'(len); i++) begin
            @(negedge clk);
            retire = 1'b1;
            miss = (i == int'(len) - 1) ? bmiss : (i < n_miss);
        end
        idle(3);
    endtask

    task automatic main_flow();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        chk("R1 reset index", int'(size_idx), MAX_IDX);
        chk("R1 reset mask", int'(sect_en), 16'hFFFF);
        chk("R1 reset pulse", int'(resize), 0);

        len = 12'd8; thr = 8'd3;
        idle(2);
        run_interval(0, 0);
        chk("R4 shrink once", int'(size_idx), 3);
        run_interval(3, 0);
        chk("R5 equal holds", int'(size_idx), 3);
        repeat (3) run_interval(0, 0);
        chk("R4 floor at minimum", int'(size_idx), MIN_IDX);
        repeat (4) run_interval(5, 0);
        chk("R3 grow saturates", int'(size_idx), MAX_IDX);
        run_interval(0, 0);
        chk("R4 shrink from full", int'(size_idx), 3);

        // closing-cycle miss belongs to the next interval
        run_interval(3, 1);
        chk("R6 closing miss excluded", int'(size_idx), 3);
        run_interval(2, 0);
        chk("R6 closing miss carried", int'(size_idx), 3);

        // zero length acts as one
        len = 12'd0; thr = 8'd0;
        idle(1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            retire = 1'b1;
            miss = 1'b1;
        end
        idle(3);
        chk("R9 zero length grows", int'(size_idx), MAX_IDX);

        // saturation: 300 misses clip to 255 == threshold -> hold
        len = 12'd300; thr = 8'd255;
        idle(1);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            retire = 1'b1;
            miss = 1'b1;
        end
        idle(3);
        chk("R9 counter saturates", int'(size_idx), MAX_IDX);

        // mixed traffic against the model
        for (int p = 0; p < 40; p++) begin
            idle(3);
            len = 12'($urandom_range(4, 20));
            thr = 8'($urandom_range(0, 10));
            for (int i = 0; i < 80; i++) begin
                @(negedge clk);
                retire = ($urandom_range(0, 9) < 7);
                miss = ($urandom_range(0, 9) < p % 10);
            end
        end
        idle(4);
    endtask

    initial begin
        fork
            main_flow();
            begin
                repeat (150000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog got=timeout exp=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule